// File: doc/BRIEF.md
# Paged GPIO Controller with Edge-Event Interrupts

This block is a 48-line general-purpose I/O peripheral behind a byte-wide host bus. The bus has a 4-bit address, a write strobe and a read strobe, which together give a 16-byte register window. The lines form six 8-bit ports. Writing a port offset loads that port's output latch, which drives `pin_out`. Reading the same offset returns the synchronized level seen on `pin_in`. To use a line as an input, the host writes 0 to its latch and lets the external pull-up or the driver set the level.

Lines 0 to 23 (ports 0, 1 and 2) can also capture edge events. Each of these lines has three bits: an enable bit, a polarity bit that chooses a rising or a falling edge, and a sticky event bit. For each of the three ports, these bits are reached through a single paged offset. A page-select register chooses which of the three bit sets that offset reaches. A summary register shows which ports hold a latched event. The `irq` output is high while any event is latched.

To acknowledge a line, the host clears its enable bit and then sets it again. Clearing the bit discards the latched event. Setting it again arms the line for the next edge.

Top module: `paged_gpio`

## Requirements
- R1: A write to offset p, where p is 0 to 5, loads port p's output latch, which appears on `pin_out[8p+7:8p]` after the write edge. No other access changes `pin_out`.
- R2: A read of offset p, where p is 0 to 5, returns the levels on `pin_in[8p+7:8p]`. These levels pass through two synchronizing flops, so a pin change is visible on reads two clock edges after it happens.
- R3: A read of offset 6 returns the event summary. Bit p, for p from 0 to 2, is 1 when port p holds at least one latched event. Bits 7:3 read 0. Writes to offset 6 have no effect.
- R4: A write to offset 7 stores the page code from data bits 7:6. The codes are 2'b10 for the enable page (byte 0x80), 2'b01 for the polarity page (0x40) and 2'b11 for the event page (0xC0). A read of offset 7 returns the code in bits 7:6 with zeros below. Reset selects the event page.
- R5: Offset 8+p, for p from 0 to 2, reads and writes port p's enable mask on the enable page and its polarity mask on the polarity page. On the event page it reads port p's latched events, and writes are ignored. Under page code 2'b00 these offsets read 0 and ignore writes.
- R6: A polarity bit of 1 makes its line latch an event on a rising edge of the synchronized pin. A polarity bit of 0 makes it latch on a falling edge.
- R7: An event bit sets only on a matching edge while its enable bit is 1. Once set, it stays set as long as the enable bit stays 1.
- R8: Writing an enable bit to 0 clears that line's event bit at the same edge. Writing the bit back to 1 re-arms the line without restoring the event.
- R9: `irq` is high exactly when at least one event bit is set. Edges on lines 24 to 47 never latch events.
- R10: After reset, all output latches, enable bits, polarity bits and event bits are 0, and `irq` is low.
- R11: Offsets 11 to 15 read 0, and writes to them have no effect. `rdata` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe; `rdata` is valid in the same cycle |
| rdata | output | 8 | Read data |
| pin_in | input | 48 | Pin levels seen from outside |
| pin_out | output | 48 | Output latch values |
| irq | output | 1 | Shared event interrupt |

## Verification
The hardest situation to reach is a latched event that must survive later activity and then be removed only by the clear-then-set sequence. That later activity includes further edges on the same line, a polarity change, and page switches that hide the event bits. The random phase mixes pin toggles on ports 0 to 2 with writes to the page register, the enable masks and the polarity masks. A bench model tracks which edges should have latched, and every read and every `irq` sample is compared against it. Directed steps also toggle lines 24 to 47, acknowledge one line while its neighbours still hold events, and select the unused page code.

// File: rtl/paged_gpio.sv
module paged_gpio #(
  parameter int PORTS     = 6,
  parameter int IRQ_PORTS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           addr,
  input  logic [7:0]           wdata,
  input  logic                 wr_en,
  input  logic                 rd_en,
  output logic [7:0]           rdata,
  input  logic [PORTS*8-1:0]   pin_in,
  output logic [PORTS*8-1:0]   pin_out,
  output logic                 irq
);
  localparam int NL = PORTS * 8;
  localparam int NI = IRQ_PORTS * 8;
  localparam logic [1:0] PG_EN  = 2'b10;
  localparam logic [1:0] PG_POL = 2'b01;
  localparam logic [1:0] PG_EVT = 2'b11;

  logic [NL-1:0] out_q, s1_q, s2_q;
  logic [NI-1:0] s3_q, en_q, pol_q, evt_q, en_nxt, pol_nxt, hit;
  logic [1:0]    page_q;
  logic [IRQ_PORTS-1:0] summary;

  wire       port_sel = int'(addr) < PORTS;
  wire       paged    = (int'(addr) >= 8) && (int'(addr) < 8 + IRQ_PORTS);
  wire [1:0] pidx     = addr[1:0];

  always_comb begin
    en_nxt  = en_q;
    pol_nxt = pol_q;
    if (wr_en && paged && page_q == PG_EN)  en_nxt[pidx*8 +: 8]  = wdata;
    if (wr_en && paged && page_q == PG_POL) pol_nxt[pidx*8 +: 8] = wdata;
  end

  wire [NI-1:0] rise = s2_q[NI-1:0] & ~s3_q;
  wire [NI-1:0] fall = ~s2_q[NI-1:0] & s3_q;
  assign hit = en_nxt & ((pol_q & rise) | (~pol_q & fall));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      s3_q   <= '0;
      en_q   <= '0;
      pol_q  <= '0;
      evt_q  <= '0;
      page_q <= PG_EVT;
    end else begin
      s1_q  <= pin_in;
      s2_q  <= s1_q;
      s3_q  <= s2_q[NI-1:0];
      en_q  <= en_nxt;
      pol_q <= pol_nxt;
      evt_q <= (evt_q | hit) & en_nxt;
      if (wr_en && port_sel) out_q[int'(addr)*8 +: 8] <= wdata;
      if (wr_en && addr == 4'd7) page_q <= wdata[7:6];
    end
  end

  for (genvar p = 0; p < IRQ_PORTS; p++) begin : g_sum
    assign summary[p] = |evt_q[p*8 +: 8];
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (port_sel) rdata = s2_q[int'(addr)*8 +: 8];
      else if (addr == 4'd6) rdata[IRQ_PORTS-1:0] = summary;
      else if (addr == 4'd7) rdata = {page_q, 6'b0};
      else if (paged) begin
        case (page_q)
          PG_EN:   rdata = en_q[pidx*8 +: 8];
          PG_POL:  rdata = pol_q[pidx*8 +: 8];
          PG_EVT:  rdata = evt_q[pidx*8 +: 8];
          default: rdata = '0;
        endcase
      end
    end
  end

  assign pin_out = out_q;
  assign irq     = |summary;

  a_r7_evt_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q & ~en_q) == '0);
  a_r7_evt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_q) & en_q & ~evt_q) == '0));
  a_r3_summary_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'd6) |-> rdata[7:IRQ_PORTS] == '0);
  a_r1_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && port_sel) |=> $stable(pin_out));
  a_r9_irq_follows_events: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q == '0) |-> !irq);
  a_r11_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 8'h00);
endmodule

// File: tb/paged_gpio_tb.sv
module paged_gpio_tb;
  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0]  addr = 0;
  logic [7:0]  wdata = 0, rdata;
  logic [47:0] pin_in = 0, pin_out;
  logic        irq;
  int tests = 0, fails = 0;

  logic [47:0] m_out = 0, m_pin = 0;
  logic [23:0] m_en = 0, m_pol = 0, m_evt = 0;
  logic [1:0]  m_page = 2'b11;

  always #4 clk = ~clk;

  paged_gpio u_dut (.clk, .rst_n, .addr, .wdata, .wr_en, .rd_en, .rdata,
                    .pin_in, .pin_out, .irq);

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(logic [3:0] a);
    logic [7:0] r = 0;
    if (a < 6) r = m_pin[a*8 +: 8];
    else if (a == 6) r = {5'b0, |m_evt[23:16], |m_evt[15:8], |m_evt[7:0]};
    else if (a == 7) r = {m_page, 6'b0};
    else if (a >= 8 && a <= 10) begin
      case (m_page)
        2'b10: r = m_en[(a-8)*8 +: 8];
        2'b01: r = m_pol[(a-8)*8 +: 8];
        2'b11: r = m_evt[(a-8)*8 +: 8];
        default: r = 0;
      endcase
    end
    return r;
  endfunction

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    if (a < 6) m_out[a*8 +: 8] = d;
    else if (a == 7) m_page = d[7:6];
    else if (a >= 8 && a <= 10) begin
      if (m_page == 2'b10) begin
        m_en[(a-8)*8 +: 8] = d;
        m_evt &= m_en;
      end else if (m_page == 2'b01) m_pol[(a-8)*8 +: 8] = d;
    end
  endtask

  task automatic rd(string tag, logic [3:0] a);
    @(negedge clk);
    addr = a; rd_en = 1;
    #1 chk(tag, rdata, exp_rd(a));
    rd_en = 0;
  endtask

  task automatic pins(logic [47:0] v);
    logic [23:0] r, f;
    @(negedge clk);
    r = v[23:0] & ~m_pin[23:0];
    f = ~v[23:0] & m_pin[23:0];
    m_evt |= m_en & ((m_pol & r) | (~m_pol & f));
    m_pin = v;
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a < 16; a++) rd(tag, 4'(a));
    chk({tag, " pin_out"}, pin_out, m_out);
    chk({tag, " irq"}, irq, |m_evt);
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state, R4 page resets to event page
    check_all("R10 reset");
    rd("R4 reset page", 4'd7);
    // R11 idle read returns zero
    @(negedge clk); addr = 4'd7; #1 chk("R11 idle rdata", rdata, 8'h00);
    // R1/R2 port latch and pin readback
    wr(4'd0, 8'hA5); wr(4'd5, 8'h3C);
    chk("R1 latch", pin_out, m_out);
    pins(48'hF0F0_1234_5678);
    rd("R2 readback p0", 4'd0); rd("R2 readback p5", 4'd5);
    // R2 two-edge synchronizer latency
    @(negedge clk); pin_in[47:40] = 8'h00; m_pin[47:40] = 8'h00;
    addr = 4'd5; rd_en = 1;
    @(negedge clk); #1 chk("R2 one edge old", rdata, 8'hF0);
    @(negedge clk); #1 chk("R2 two edges new", rdata, 8'h00);
    rd_en = 0;
    // R5/R6 rising edge on line 3, falling on line 9
    pins(48'h0);
    wr(4'd7, 8'h80); wr(4'd8, 8'h08); wr(4'd9, 8'h02);
    wr(4'd7, 8'h40); wr(4'd8, 8'h08);
    rd("R5 pol page", 4'd8);
    wr(4'd7, 8'hC0);
    pins(48'h0000_0000_0200);
    pins(48'h0000_0000_0008);
    rd("R6 rising p0", 4'd8); rd("R6 falling p1", 4'd9);
    rd("R3 summary", 4'd6);
    chk("R9 irq set", irq, 1'b1);
    // R5 event page writes ignored, R3 summary write ignored
    wr(4'd8, 8'h00); wr(4'd6, 8'h00);
    rd("R5 evt write ignored", 4'd8); rd("R3 write ignored", 4'd6);
    // R7 sticky through more edges
    pins(48'h0);
    rd("R7 sticky", 4'd8);
    // R8 acknowledge line 3 only
    wr(4'd7, 8'h80); wr(4'd8, 8'h00); wr(4'd8, 8'h08); wr(4'd7, 8'hC0);
    rd("R8 ack cleared", 4'd8); rd("R8 neighbour kept", 4'd9);
    chk("R8 irq kept", irq, |m_evt);
    wr(4'd7, 8'h80); wr(4'd9, 8'h00); wr(4'd7, 8'hC0);
    chk("R9 irq low", irq, 1'b0);
    // R9 upper ports never latch
    pins(48'hFFFF_FF00_0000); pins(48'h0);
    rd("R9 no upper events", 4'd6);
    // R5 unused page code, R11 high offsets
    wr(4'd7, 8'h00); wr(4'd8, 8'hFF);
    rd("R5 page 00 read", 4'd8);
    wr(4'd12, 8'hFF);
    check_all("R11 high offsets");
    // random phase
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) pins({$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF);
      else if (op < 4) wr(4'd7, 8'($urandom_range(0, 3) << 6));
      else if (op < 7) wr(4'($urandom_range(8, 10)), 8'($urandom()));
      else if (op < 8) wr(4'($urandom_range(0, 15)), 8'($urandom()));
      else rd("R7 random read", 4'($urandom_range(0, 15)));
      chk("R9 random irq", irq, |m_evt);
    end
    check_all("R6 random final");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule